// File: doc/BRIEF.md
# Multi-Counter Performance Monitor

A small bank of 32-bit event counters sits on a simple register bus. It gives a processor core cheap, software-driven profiling. Each counter takes its events from one group of sixteen sub-event strobes. A control word picks the group, and a 16-bit mask picks which strobes in that group count. Special selections give a free-running cycle count and cascading from the next lower counter. A single master-enable bit freezes the whole bank at once.

Counting is gated by the privilege of the core and by its current interrupt level. Kernel-mode events count only when a counter opts in. Events raised above a counter's trace level are dropped. Software preloads a negative value so that a counter wraps after a chosen number of events. The wrap sets a sticky overflow flag and, if enabled, an interrupt flag. The interrupt flags of all counters drive one shared profiling interrupt. Software clears the status flags by writing ones back to them.

Top module: `perf_mon`

## Requirements
- R1: After reset every value, control, status and master-enable register reads 0, and `prof_irq` is 0.
- R2: Byte addresses: the master register is at 0x1000, and counter i has its value at 0x1080+4i, its control word at 0x1100+4i and its status at 0x1180+4i. `bus_rdata` holds the addressed register one clock after the address is presented, and unmapped addresses read 0. Control bits other than 0, 3, 7:4, 12:8 and 31:16 are not stored and read 0.
- R3: While bit 0 of the master register is 0, no counter changes except by a bus write.
- R4: Control field 12:8 selects a group g. In any clock where `evt_strobe[16g+15:16g]` ANDed with control field 31:16 is nonzero, and counting is permitted, the counter rises by exactly 1.
- R5: Group 0, sub-event 0 is tied high inside the block, so select 0 with mask bit 16 set counts every enabled clock, whatever the strobe inputs are.
- R6: Select value 1 makes counter i advance by 1 in each clock where counter i-1 wraps. Counter 0 with select 1 never advances.
- R7: While `priv_kernel` is 1, a counter advances only if its control bit 3 is set. While `priv_kernel` is 0, the privilege input does not limit counting.
- R8: An event is dropped when `irq_level` is greater than control field 7:4.
- R9: A bus write to a value register loads it. In the same clock the write takes precedence over a count.
- R10: A counted event at 0xFFFFFFFF wraps the counter to 0. The same clock sets status bit 0, and it also sets status bit 4 if control bit 0 is 1.
- R11: Writing a status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R12: `prof_irq` is the OR of status bit 4 over all counters, registered once. It stays 1 until every such bit is cleared.
- R13: A counter whose control word is 0 does not advance on any strobe pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 13 | Byte address for reads and writes |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_strobe | input | NGRP*16 | Sub-event strobes; group g occupies bits 16g+15:16g |
| priv_kernel | input | 1 | 1 while the core runs in kernel mode |
| irq_level | input | 4 | Current interrupt level of the core |
| prof_irq | output | 1 | Shared profiling interrupt |

## Verification
The assertions assume that the bus writes a register only as a whole word, that reset is held for at least one clock before use, and that any counter step other than a bus load is +1. The stimulus changes strobes, privilege and interrupt level only on falling edges. It opens counting windows with master-enable writes, so the expected count is exactly the window length or zero. It writes only the addresses the requirements list.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 13;
  localparam int SUB_W  = 16;
  localparam int SEL_W  = 5;

  localparam logic [ADDR_W-1:0] MASTER_ADDR = 13'h1000;
  localparam logic [ADDR_W-1:0] VALUE_BASE  = 13'h1080;
  localparam logic [ADDR_W-1:0] CTRL_BASE   = 13'h1100;
  localparam logic [ADDR_W-1:0] STAT_BASE   = 13'h1180;

  localparam logic [SEL_W-1:0]  SEL_CASCADE = 5'd1;
  localparam logic [DATA_W-1:0] CTRL_KEEP   = 32'hFFFF_1FF9;

  typedef struct packed {
    logic [SUB_W-1:0] mask;
    logic [2:0]       rsv_hi;
    logic [SEL_W-1:0] sel;
    logic [3:0]       tlevel;
    logic             kmode;
    logic [1:0]       rsv_lo;
    logic             irq_en;
  } ctrl_t;
endpackage

// File: rtl/pmu_event_match.sv
module pmu_event_match
  import pmu_pkg::*;
#(
  parameter int NGRP = 16
) (
  input  logic [NGRP*SUB_W-1:0] evt,
  input  logic [SEL_W-1:0]      sel,
  input  logic [SUB_W-1:0]      mask,
  output logic                  hit
);
  logic [SUB_W-1:0] grp [NGRP];

  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      if (g == 0) begin : g_cycle
        assign grp[g] = {evt[SUB_W-1:1], 1'b1};
      end else if (g == 1) begin : g_cascade
        assign grp[g] = '0;
      end else begin : g_plain
        assign grp[g] = evt[g*SUB_W +: SUB_W];
      end
    end
  endgenerate

  always_comb begin
    hit = 1'b0;
    for (int g = 0; g < NGRP; g++)
      if (sel == SEL_W'(g)) hit = |(grp[g] & mask);
  end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter
  import pmu_pkg::*;
#(
  parameter int NGRP = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  glob_en,
  input  logic [NGRP*SUB_W-1:0] evt,
  input  logic                  priv_kernel,
  input  logic [3:0]            irq_level,
  input  logic                  chain_in,
  input  logic                  val_we,
  input  logic                  ctl_we,
  input  logic                  sts_we,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     value,
  output ctrl_t                 ctrl,
  output logic                  sts_ovf,
  output logic                  sts_int,
  output logic                  wrap_out
);
  logic grp_hit, hit, gate, step;

  pmu_event_match #(.NGRP(NGRP)) i_match (
    .evt (evt),
    .sel (ctrl.sel),
    .mask(ctrl.mask),
    .hit (grp_hit)
  );

  assign hit      = (ctrl.sel == SEL_CASCADE) ? chain_in : grp_hit;
  assign gate     = glob_en && (!priv_kernel || ctrl.kmode) && (irq_level <= ctrl.tlevel);
  assign step     = hit && gate;
  assign wrap_out = step && !val_we && (value == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      value   <= '0;
      ctrl    <= '0;
      sts_ovf <= 1'b0;
      sts_int <= 1'b0;
    end else begin
      if (val_we)    value <= wdata;
      else if (step) value <= value + 1'b1;
      if (ctl_we) ctrl <= ctrl_t'(wdata & CTRL_KEEP);
      sts_ovf <= wrap_out | (sts_ovf & !(sts_we && wdata[0]));
      sts_int <= (wrap_out & ctrl.irq_en) | (sts_int & !(sts_we && wdata[4]));
    end
  end

  // R3
  frozen_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!glob_en && !val_we) |=> $stable(value));

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    !val_we |=> (value == $past(value) || value == DATA_W'($past(value) + 1'b1)));

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (sts_ovf && !(sts_we && wdata[0])) |=> sts_ovf);

  // R10
  int_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_int) |-> $past(ctrl.irq_en));
endmodule

// File: rtl/perf_mon.sv
module perf_mon
  import pmu_pkg::*;
#(
  parameter int NCNT = 4,
  parameter int NGRP = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [NGRP*SUB_W-1:0] evt_strobe,
  input  logic                  priv_kernel,
  input  logic [3:0]            irq_level,
  output logic                  prof_irq
);
  logic              master_en;
  logic [DATA_W-1:0] value [NCNT];
  ctrl_t             ctrl  [NCNT];
  logic [NCNT-1:0]   ovf_bits, int_bits, wrap;
  logic [NCNT:0]     chain;
  logic [DATA_W-1:0] rd_next;

  assign chain[0] = 1'b0;

  generate
    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
      localparam logic [ADDR_W-1:0] VA = VALUE_BASE + ADDR_W'(4*i);
      localparam logic [ADDR_W-1:0] CA = CTRL_BASE  + ADDR_W'(4*i);
      localparam logic [ADDR_W-1:0] SA = STAT_BASE  + ADDR_W'(4*i);

      pmu_counter #(.NGRP(NGRP)) i_cnt (
        .clk        (clk),
        .rst        (rst),
        .glob_en    (master_en),
        .evt        (evt_strobe),
        .priv_kernel(priv_kernel),
        .irq_level  (irq_level),
        .chain_in   (chain[i]),
        .val_we     (bus_we && bus_addr == VA),
        .ctl_we     (bus_we && bus_addr == CA),
        .sts_we     (bus_we && bus_addr == SA),
        .wdata      (bus_wdata),
        .value      (value[i]),
        .ctrl       (ctrl[i]),
        .sts_ovf    (ovf_bits[i]),
        .sts_int    (int_bits[i]),
        .wrap_out   (wrap[i])
      );
      assign chain[i+1] = wrap[i];
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    if (bus_addr == MASTER_ADDR) rd_next = {{(DATA_W-1){1'b0}}, master_en};
    for (int i = 0; i < NCNT; i++) begin
      if (bus_addr == VALUE_BASE + ADDR_W'(4*i)) rd_next = value[i];
      if (bus_addr == CTRL_BASE  + ADDR_W'(4*i)) rd_next = DATA_W'(ctrl[i]);
      if (bus_addr == STAT_BASE  + ADDR_W'(4*i))
        rd_next = {27'd0, int_bits[i], 3'd0, ovf_bits[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      master_en <= 1'b0;
      bus_rdata <= '0;
      prof_irq  <= 1'b0;
    end else begin
      if (bus_we && bus_addr == MASTER_ADDR) master_en <= bus_wdata[0];
      bus_rdata <= rd_next;
      prof_irq  <= |int_bits;
    end
  end

  // R12
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (|int_bits) |=> prof_irq);

  // R12
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(prof_irq) |-> $past(|int_bits));
endmodule

// File: tb/test_perf_mon.sv
module test_perf_mon;
  localparam int NCNT = 4;
  localparam int NGRP = 16;

  logic                clk = 1'b0;
  logic                rst;
  logic [12:0]         bus_addr;
  logic                bus_we;
  logic [31:0]         bus_wdata;
  logic [31:0]         bus_rdata;
  logic [NGRP*16-1:0]  evt_strobe;
  logic                priv_kernel;
  logic [3:0]          irq_level;
  logic                prof_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  perf_mon #(.NCNT(NCNT), .NGRP(NGRP)) i_perf_mon (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_strobe(evt_strobe),
    .priv_kernel(priv_kernel), .irq_level(irq_level), .prof_irq(prof_irq)
  );

  localparam logic [12:0] MA = 13'h1000;
  function automatic logic [12:0] va(int i); return 13'h1080 + 13'(4*i); endfunction
  function automatic logic [12:0] ca(int i); return 13'h1100 + 13'(4*i); endfunction
  function automatic logic [12:0] sa(int i); return 13'h1180 + 13'(4*i); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [12:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [12:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // k counting clocks (k >= 1)
  task automatic run(int k);
    wr(MA, 1);
    repeat (k-1) @(negedge clk);
    wr(MA, 0);
  endtask

  task automatic clear_ctrls();
    for (int i = 0; i < NCNT; i++) wr(ca(i), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    evt_strobe = '0; priv_kernel = 1'b0; irq_level = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(MA, d); check("R1 master", d, 0);
    for (int i = 0; i < NCNT; i++) begin
      rd(va(i), d); check("R1 value", d, 0);
      rd(ca(i), d); check("R1 ctrl", d, 0);
      rd(sa(i), d); check("R1 status", d, 0);
    end
    check("R1 prof_irq", 32'(prof_irq), 0);

    // R2 map, stored bits, unmapped
    wr(ca(2), 32'hFFFF_FFFF); rd(ca(2), d); check("R2 ctrl bits", d, 32'hFFFF_1FF9);
    wr(ca(2), 0);
    wr(va(3), 32'h1234_5678); rd(va(3), d); check("R2 value rw", d, 32'h1234_5678);
    rd(va(NCNT), d); check("R2 unmapped", d, 0);
    rd(13'h1004, d); check("R2 unmapped", d, 0);

    // R5 cycle event, window sweep, strobes all 0
    wr(ca(0), 32'h0001_00F0);
    for (int k = 1; k <= 6; k++) begin
      wr(va(0), 0); run(k); rd(va(0), d); check("R5 cycle count", d, 32'(k));
    end

    // R3 master off: nothing moves
    wr(va(0), 7);
    repeat (10) @(negedge clk);
    rd(va(0), d); check("R3 frozen", d, 7);
    clear_ctrls();

    // R4 group/mask sweep on counter 3
    for (int g = 2; g < NGRP; g++)
      for (int b = 0; b < 16; b++)
        for (int m = 0; m < 2; m++) begin
          int s;
          s = (m == 0) ? b : (b + 1) % 16;
          wr(ca(3), (32'(1) << (16 + b)) | (32'(g) << 8) | 32'hF0);
          evt_strobe = '0; evt_strobe[g*16 + s] = 1'b1;
          wr(va(3), 0); run(3); rd(va(3), d);
          check("R4 group mask", d, (s == b) ? 3 : 0);
        end
    evt_strobe = '0;
    clear_ctrls();

    // R6 cascade
    wr(ca(0), 32'h0001_00F0); wr(ca(1), 32'h0001_01F0);
    wr(va(0), 32'hFFFF_FFFE); wr(va(1), 0);
    run(5);
    rd(va(0), d); check("R6 lower", d, 3);
    rd(va(1), d); check("R6 upper", d, 1);
    wr(ca(0), 32'h0001_01F0); run(4);
    rd(va(0), d); check("R6 counter0 cascade", d, 3);
    clear_ctrls();
    wr(sa(0), 32'h11);

    // R7 privilege
    priv_kernel = 1'b1;
    wr(ca(0), 32'h0001_00F0); wr(va(0), 0); run(4);
    rd(va(0), d); check("R7 kernel blocked", d, 0);
    wr(ca(0), 32'h0001_00F8); wr(va(0), 0); run(4);
    rd(va(0), d); check("R7 kernel allowed", d, 4);
    priv_kernel = 1'b0;

    // R8 trace level 5, level sweep
    wr(ca(0), 32'h0001_0050);
    for (int l = 0; l < 16; l++) begin
      irq_level = 4'(l);
      wr(va(0), 0); run(3); rd(va(0), d);
      check("R8 level gate", d, (l <= 5) ? 3 : 0);
    end
    irq_level = '0;

    // R9 write beats count
    wr(ca(0), 32'h0001_00F0);
    wr(MA, 1); wr(va(0), 100); wr(MA, 0);
    rd(va(0), d); check("R9 load wins", d, 101);
    clear_ctrls();

    // R10 overflow without interrupt enable, R11 write-0 no effect
    wr(ca(1), 32'h0001_00F0); wr(va(1), 32'hFFFF_FFFF); run(1);
    rd(va(1), d); check("R10 wrap", d, 0);
    rd(sa(1), d); check("R10 ovf only", d, 32'h01);
    check("R12 no irq", 32'(prof_irq), 0);
    wr(sa(1), 0); rd(sa(1), d); check("R11 zero keeps", d, 32'h01);
    wr(sa(1), 32'h01); rd(sa(1), d); check("R11 clear", d, 0);
    wr(ca(1), 0);

    // R10 / R12 two interrupt sources
    wr(ca(2), 32'h0001_00F1); wr(ca(3), 32'h0001_00F1);
    wr(va(2), 32'hFFFF_FFFD); wr(va(3), 32'hFFFF_FFFE);
    run(2);
    rd(va(2), d); check("R10 pre-wrap", d, 32'hFFFF_FFFF);
    rd(sa(2), d); check("R10 no flag yet", d, 0);
    rd(sa(3), d); check("R10 ovf+int", d, 32'h11);
    check("R12 irq set", 32'(prof_irq), 1);
    run(1);
    rd(sa(2), d); check("R10 ovf+int", d, 32'h11);
    wr(sa(3), 32'h11); @(negedge clk);
    rd(sa(3), d); check("R11 clear both", d, 0);
    check("R12 irq held", 32'(prof_irq), 1);
    wr(sa(2), 32'h01); @(negedge clk);
    rd(sa(2), d); check("R11 partial", d, 32'h10);
    check("R12 irq held", 32'(prof_irq), 1);
    wr(sa(2), 32'h10); @(negedge clk); @(negedge clk);
    check("R12 irq drops", 32'(prof_irq), 0);
    clear_ctrls();

    // R13 zero control stops counting
    evt_strobe = '1;
    wr(va(0), 55); run(5);
    rd(va(0), d); check("R13 stopped", d, 55);
    evt_strobe = '0;

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule